// File: doc/BRIEF.md
# Indirect Branch Target Predictor with Target History

This block guesses where an indirect jump or indirect call will land, for branches whose destination comes from a register or from memory rather than from an immediate. The fetch stage asks for a guess only when it has already decided the branch is taken. It presents the fetch address and gets back a predicted destination and a hit flag on the following clock. When the branch resolves, the back end reports the branch address and the destination it actually reached. That report trains two structures and advances a shared history of recent indirect outcomes.

The main structure is a direct-mapped, partially tagged table. Its index mixes the branch address with that history, so one branch site that cycles through several destinations uses a different entry for each position in its cycle. Each outcome adds two address bits to the history, which lets the table tell more than two destinations apart. A second direct-mapped table, indexed by address only, remembers the last destination seen for each branch. It serves as the fallback when the history-mixed lookup misses. A flush input clears the history alone, for example after a pipeline redirect, and leaves both tables intact.

Top module: `indirect_target_predictor`

## Requirements
- R1: `pred_valid` is high exactly one clock after a clock in which `pred_req` was high, and low otherwise; `pred_hit` and `pred_target` for that request appear in the same clock as `pred_valid`.
- R2: The history table uses index = pc[7:2] XOR fold(history) and tag = pc[13:8]. Here fold(h) = h[5:0] XOR {4'b0, h[7:6]}, for an 8-bit history. A lookup hits when the indexed entry is valid and its tag matches, and it returns the stored target.
- R3: A hit in the history table takes priority. If it misses, a valid last-target entry (index pc[7:2], tag pc[13:8]) supplies the target. If both miss, `pred_hit` is 0 and `pred_target` is 0.
- R4: An update writes {tag, target} into the history-table entry selected by the history value before the update. It also writes the last-target entry for `upd_pc`. The history then shifts left by two bits, and `upd_target[3:2]` enters at bits [1:0].
- R5: Prediction requests and idle clocks leave the history unchanged.
- R6: `flush_hist` zeroes the history on the next clock and overrides the shift of an update in the same clock. That update still writes both tables, using the history value before the flush.
- R7: A prediction issued in the same clock as an update sees the table contents and history from before that update.
- R8: Synchronous reset invalidates every entry of both tables and zeroes the history.
- R9: After warm-up, one branch site that repeats a target sequence of period 2, 3 or 4 is predicted correctly on every execution, provided each history context maps to its own entry.
- R10: An update whose index collides with an entry that has a different tag overwrites that entry in both direct-mapped tables. The displaced branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_hist | input | 1 | Clear the target history |
| pred_req | input | 1 | Prediction request for a taken indirect branch |
| pred_pc | input | 32 | Fetch address of the branch to predict |
| upd_valid | input | 1 | A resolved indirect branch is reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Destination the resolved branch reached |
| pred_valid | output | 1 | Prediction result is present |
| pred_hit | output | 1 | A table supplied the predicted target |
| pred_target | output | 32 | Predicted destination, zero on a miss |

## Verification
The hardest situation to reach from the ports is a steady state where the history table alone produces the right answer and the last-target table would be wrong. The bench reaches it by having one branch address resolve in a repeating target cycle, with a prediction in every clock. Once the warm-up has filled every history context, every prediction must match the target that comes next. A second hard case is a clock that carries both a flush and an update. The bench exposes it through later lookups: one reads the entry selected by the cleared history, and another reads the entry that the update wrote under the history value from before the flush.

// File: rtl/itp_pkg.sv
package itp_pkg;

  // Which structure supplied the current prediction
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HIST = 2'd1,
    SRC_LAST = 2'd2
  } pred_src_e;

  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_PC_LSB  = 2;
  localparam int unsigned DEF_IDX_W   = 6;
  localparam int unsigned DEF_TAG_W   = 6;
  localparam int unsigned DEF_HIST_N  = 4;
  localparam int unsigned DEF_BPO     = 2;

endpackage

// File: rtl/itp_hist_reg.sv
module itp_hist_reg #(
  parameter int unsigned HIST_W = 8,
  parameter int unsigned BPO    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              shift_en,
  input  logic [BPO-1:0]    shift_in,
  output logic [HIST_W-1:0] hist
);

  // Older outcomes move toward the top; the newest sits in the low bits
  function automatic logic [HIST_W-1:0] push_outcome(
    input logic [HIST_W-1:0] cur,
    input logic [BPO-1:0]    nxt
  );
    return {cur[HIST_W-BPO-1:0], nxt};
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hist <= '0;
    end else if (shift_en) begin
      hist <= push_outcome(hist, shift_in);
    end
  end

endmodule

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned HIST_W   = 8,
  parameter bit          USE_HIST = 1'b1
) (
  input  logic [IDX_W+TAG_W-1:0] pc_bits,
  input  logic [HIST_W-1:0]      hist,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       tag
);

  // XOR-fold the history down to the index width, bit b landing on b mod IDX_W
  function automatic logic [IDX_W-1:0] fold_hist(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < HIST_W; b++) begin
      r[b % IDX_W] = r[b % IDX_W] ^ h[b];
    end
    return r;
  endfunction

  logic [HIST_W-1:0] hist_eff;

  generate
    if (USE_HIST) begin : g_mix
      assign hist_eff = hist;
    end else begin : g_plain
      assign hist_eff = hist & '0;
    end
  endgenerate

  assign idx = pc_bits[IDX_W-1:0] ^ fold_hist(hist_eff);
  assign tag = pc_bits[IDX_W +: TAG_W];

endmodule

// File: rtl/itp_table.sv
module itp_table #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_alloc
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [DATA_W-1:0] dat_mem [DEPTH];

  logic wr_same;

  // An entry is allocated unless it already holds this tag and target
  assign wr_same  = vld[wr_idx] && (tag_mem[wr_idx] == wr_tag) &&
                    (dat_mem[wr_idx] == wr_data);
  assign wr_alloc = wr_en && !wr_same;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (wr_alloc) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_alloc) begin
      tag_mem[wr_idx] <= wr_tag;
      dat_mem[wr_idx] <= wr_data;
    end
  end

  // Registered lookup: reads the state present before this edge's write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_hit  <= rd_en && vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
      rd_data <= dat_mem[rd_idx];
    end
  end

endmodule

// File: rtl/indirect_target_predictor.sv
module indirect_target_predictor #(
  parameter int unsigned PC_W             = itp_pkg::DEF_PC_W,
  parameter int unsigned PC_LSB           = itp_pkg::DEF_PC_LSB,
  parameter int unsigned IDX_W            = itp_pkg::DEF_IDX_W,
  parameter int unsigned TAG_W            = itp_pkg::DEF_TAG_W,
  parameter int unsigned HIST_N           = itp_pkg::DEF_HIST_N,
  parameter int unsigned BITS_PER_OUTCOME = itp_pkg::DEF_BPO
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush_hist,
  input  logic            pred_req,
  input  logic [PC_W-1:0] pred_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_target
);
  import itp_pkg::*;

  localparam int unsigned HIST_W = HIST_N * BITS_PER_OUTCOME;
  localparam int unsigned KEY_W  = IDX_W + TAG_W;
  localparam int unsigned KEY_HI = PC_LSB + KEY_W;

  // Named internal events, observed by the bound checker
  logic [HIST_W-1:0] hist;
  logic              hist_alloc;
  logic              last_alloc;
  pred_src_e         pred_src;

  logic [IDX_W-1:0]  hp_idx, hu_idx, lp_idx, lu_idx;
  logic [TAG_W-1:0]  hp_tag, hu_tag, lp_tag, lu_tag;
  logic              hh_hit, lh_hit;
  logic [PC_W-1:0]   hh_data, lh_data;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:KEY_HI], pred_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:KEY_HI], upd_pc[PC_LSB-1:0]};

  itp_hist_reg #(.HIST_W(HIST_W), .BPO(BITS_PER_OUTCOME)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush_hist),
    .shift_en (upd_valid),
    .shift_in (upd_target[PC_LSB +: BITS_PER_OUTCOME]),
    .hist     (hist)
  );

  // Hash units: history-mixed for the pattern table, address-only for fallback
  itp_hash #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .USE_HIST(1'b1)) u_hash_hp (
    .pc_bits (pred_pc[PC_LSB +: KEY_W]), .hist (hist), .idx (hp_idx), .tag (hp_tag)
  );
  itp_hash #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .USE_HIST(1'b1)) u_hash_hu (
    .pc_bits (upd_pc[PC_LSB +: KEY_W]), .hist (hist), .idx (hu_idx), .tag (hu_tag)
  );
  itp_hash #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .USE_HIST(1'b0)) u_hash_lp (
    .pc_bits (pred_pc[PC_LSB +: KEY_W]), .hist (hist), .idx (lp_idx), .tag (lp_tag)
  );
  itp_hash #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .USE_HIST(1'b0)) u_hash_lu (
    .pc_bits (upd_pc[PC_LSB +: KEY_W]), .hist (hist), .idx (lu_idx), .tag (lu_tag)
  );

  itp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(PC_W)) u_hist_tbl (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_req),
    .rd_idx   (hp_idx),
    .rd_tag   (hp_tag),
    .rd_hit   (hh_hit),
    .rd_data  (hh_data),
    .wr_en    (upd_valid),
    .wr_idx   (hu_idx),
    .wr_tag   (hu_tag),
    .wr_data  (upd_target),
    .wr_alloc (hist_alloc)
  );

  itp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(PC_W)) u_last_tbl (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (pred_req),
    .rd_idx   (lp_idx),
    .rd_tag   (lp_tag),
    .rd_hit   (lh_hit),
    .rd_data  (lh_data),
    .wr_en    (upd_valid),
    .wr_idx   (lu_idx),
    .wr_tag   (lu_tag),
    .wr_data  (upd_target),
    .wr_alloc (last_alloc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
    end else begin
      pred_valid <= pred_req;
    end
  end

  // Pattern hit first, then last target, else no prediction
  always_comb begin
    if (hh_hit) begin
      pred_src = SRC_HIST;
    end else if (lh_hit) begin
      pred_src = SRC_LAST;
    end else begin
      pred_src = SRC_NONE;
    end
  end

  always_comb begin
    case (pred_src)
      SRC_HIST: pred_target = hh_data;
      SRC_LAST: pred_target = lh_data;
      default:  pred_target = '0;
    endcase
  end

  assign pred_hit = (pred_src != SRC_NONE);

endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 8,
  parameter int unsigned BPO    = 2,
  parameter int unsigned PC_LSB = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                flush_hist,
  input logic                pred_req,
  input logic                upd_valid,
  input logic [PC_W-1:0]     upd_target,
  input logic                pred_valid,
  input logic                pred_hit,
  input logic [PC_W-1:0]     pred_target,
  input logic [HIST_W-1:0]   hist,
  input itp_pkg::pred_src_e  pred_src,
  input logic                hist_alloc,
  input logic                last_alloc
);
  import itp_pkg::*;

  // R1: result appears one clock after a request, and only then
  a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    (!rst && pred_req) |=> pred_valid);
  a_r1_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    (!rst && !pred_req) |=> !pred_valid);

  // R3: hit implies a present result; a miss drives a zero target
  a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    pred_hit |-> pred_valid);
  a_r3_miss_zero_target: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> (pred_target == '0));
  a_r3_source_is_hit: assert property (@(posedge clk) disable iff (rst)
    (pred_src == SRC_HIST) |-> (pred_hit && pred_valid));

  // R4: an update shifts the resolved target bits into the history
  a_r4_history_shift: assert property (@(posedge clk) disable iff (rst)
    (!rst && upd_valid && !flush_hist) |=>
      (hist == {$past(hist[HIST_W-BPO-1:0]), $past(upd_target[PC_LSB +: BPO])}));
  a_r4_alloc_on_update: assert property (@(posedge clk) disable iff (rst)
    (hist_alloc || last_alloc) |-> upd_valid);

  // R5: history holds without an update
  a_r5_history_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !upd_valid && !flush_hist) |=> $stable(hist));

  // R6: flush clears the history
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    (!rst && flush_hist) |=> (hist == '0));

  // R8: reset clears history and output valid
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> ((hist == '0) && !pred_valid));

endmodule

bind indirect_target_predictor itp_checker #(
  .PC_W   (PC_W),
  .HIST_W (HIST_W),
  .BPO    (BITS_PER_OUTCOME),
  .PC_LSB (PC_LSB)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush_hist  (flush_hist),
  .pred_req    (pred_req),
  .upd_valid   (upd_valid),
  .upd_target  (upd_target),
  .pred_valid  (pred_valid),
  .pred_hit    (pred_hit),
  .pred_target (pred_target),
  .hist        (hist),
  .pred_src    (pred_src),
  .hist_alloc  (hist_alloc),
  .last_alloc  (last_alloc)
);

// File: tb/indirect_target_predictor_test.sv
module indirect_target_predictor_test;

  localparam logic [31:0] PA = 32'h0000_1040; // index 0x10, tag 0x10
  localparam logic [31:0] PB = 32'h0000_2040; // index 0x10, tag 0x20
  localparam logic [31:0] PC = 32'h0000_3080; // index 0x20, tag 0x30
  localparam logic [31:0] T1 = 32'h2000_0004; // bits[3:2] = 01
  localparam logic [31:0] T2 = 32'h2000_0008; // bits[3:2] = 10
  localparam logic [31:0] T3 = 32'h2000_000C; // bits[3:2] = 11

  typedef struct packed {
    logic        req;
    logic [31:0] ppc;
    logic        upd;
    logic [31:0] upc;
    logic [31:0] utgt;
    logic        flush;
    logic        ehit;
    logic [31:0] etgt;
  } vec_t;

  // Expected results worked out by hand from R2, R3, R4, R6, R7
  localparam vec_t VECS [0:7] = '{
    '{1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0}, // empty tables miss
    '{1'b0, 32'h0, 1'b1, PA, T1, 1'b0, 1'b0, 32'h0},    // train A->T1 at hist 0
    '{1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, T1},    // hist 01: fallback T1
    '{1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0}, // flush
    '{1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, T1},    // hist 0: pattern T1
    '{1'b1, PA, 1'b1, PA, T2, 1'b0, 1'b1, T1},          // same clock sees old
    '{1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, T2},    // hist 10: fallback T2
    '{1'b1, PB, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0}  // B tag differs: miss
  };

  logic        clk;
  logic        rst;
  logic        flush_hist;
  logic        pred_req;
  logic [31:0] pred_pc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [31:0] upd_target;
  logic        pred_valid;
  logic        pred_hit;
  logic [31:0] pred_target;

  int total;
  int bad;

  indirect_target_predictor uut (
    .clk         (clk),
    .rst         (rst),
    .flush_hist  (flush_hist),
    .pred_req    (pred_req),
    .pred_pc     (pred_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_target  (upd_target),
    .pred_valid  (pred_valid),
    .pred_hit    (pred_hit),
    .pred_target (pred_target)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 2 ns after the rising edge
  task automatic step(input logic req, input logic [31:0] ppc, input logic upd,
                      input logic [31:0] upc, input logic [31:0] utgt, input logic fl);
    @(negedge clk);
    pred_req = req; pred_pc = ppc; upd_valid = upd;
    upd_pc = upc; upd_target = utgt; flush_hist = fl;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pred_req = 1'b0; pred_pc = '0; upd_valid = 1'b0;
    upd_pc = '0; upd_target = '0; flush_hist = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] pat_target(input int period, input int k);
    int s;
    s = k % period;
    if (period == 2) return (s == 0) ? T1 : T2;
    if (period == 3) return (s == 0) ? T1 : (s == 1) ? T2 : T3;
    return (s == 0 || s == 1) ? T1 : (s == 2) ? T2 : T3; // period 4: T1 T1 T2 T3
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    do_reset();
    // R8: reset state at the outputs
    chk("R8 reset pred_valid", {31'b0, pred_valid}, 32'd0);
    chk("R8 reset pred_hit", {31'b0, pred_hit}, 32'd0);

    // Vector walk (R1, R2, R3, R4, R6, R7)
    for (int i = 0; i < 8; i++) begin
      step(VECS[i].req, VECS[i].ppc, VECS[i].upd, VECS[i].upc, VECS[i].utgt, VECS[i].flush);
      chk($sformatf("R1 vec%0d valid", i), {31'b0, pred_valid}, {31'b0, VECS[i].req});
      chk($sformatf("R3 vec%0d hit", i), {31'b0, pred_hit}, {31'b0, VECS[i].ehit});
      chk($sformatf("R2 vec%0d target", i), pred_target, VECS[i].etgt);
    end

    // R9: periodic target sequences at one site, steady state must be exact
    for (int p = 2; p <= 4; p++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        step(1'b1, PA, 1'b1, PA, pat_target(p, k), 1'b0);
        if (k >= 24) begin
          chk($sformatf("R9 period%0d step%0d", p, k), pred_target, pat_target(p, k));
        end
      end
    end

    // R8: reset forgets trained entries
    do_reset();
    step(1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R8 after reset miss", {31'b0, pred_hit}, 32'd0);

    // R3 priority and R5 history hold under repeated predictions
    do_reset();
    step(1'b0, 32'h0, 1'b1, PA, T1, 1'b0); // hist 0 -> entry T1
    step(1'b0, 32'h0, 1'b1, PA, T2, 1'b0); // hist 01 -> entry T2, last = T2
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
    for (int r = 0; r < 3; r++) begin
      step(1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0);
      chk($sformatf("R3 R5 pattern over last %0d", r), pred_target, T1);
    end

    // R6: flush and update in one clock
    do_reset();
    step(1'b0, 32'h0, 1'b1, PA, T1, 1'b0);  // hist -> 01
    step(1'b0, 32'h0, 1'b1, PA, T2, 1'b1);  // writes at hist 01, hist -> 0
    step(1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R6 flush wins over shift", pred_target, T1);
    step(1'b0, 32'h0, 1'b1, PC, T1, 1'b0);  // hist -> 01
    step(1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R6 write under flush kept", pred_target, T2);

    // R10: index conflict overwrites both tables
    do_reset();
    step(1'b0, 32'h0, 1'b1, PA, T1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
    step(1'b0, 32'h0, 1'b1, PB, T2, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1);
    step(1'b1, PA, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R10 displaced branch misses", {31'b0, pred_hit}, 32'd0);
    chk("R10 displaced target zero", pred_target, 32'h0);
    step(1'b1, PB, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R10 new owner hits", pred_target, T2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule